// File: doc/BRIEF.md
# Prioritized Shift and Load Register

This block is a parameterized register that can hold its contents, take a full word in parallel, or move its contents one place in either direction. Three independent request lines ask for a parallel load, a right shift and a left shift. A small fixed-priority encoder resolves them into a two-bit mode select, and that select drives a four-way multiplexer in front of every flip-flop.

Requests are resolved in a fixed order. Load beats both shifts, and a right shift beats a left shift. When no request is raised, the multiplexer feeds each bit's own output back to it, so the register holds its value. Each shift direction has its own serial-in bit, which fills the position left empty by the shift. A synchronous active-low reset clears the register and overrides every request.

The block suits datapaths that build serial arithmetic or framing from a word register. The surrounding control logic can raise requests freely without first encoding them.

Top module: `prio_shift_reg`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `q_out` becomes all zeros after that edge, whatever the request lines are.
- R2: When `req_load` is high at an edge, `q_out` takes `par_in` after that edge, whatever `req_shr` and `req_shl` are.
- R3: With `req_load` low and `req_shr` high, each bit moves one place toward bit 0, and the top bit takes `ser_msb_in`. `req_shl` has no effect in this case.
- R4: With `req_load` and `req_shr` low and `req_shl` high, each bit moves one place toward the top bit, and bit 0 takes `ser_lsb_in`.
- R5: With all three requests low, `q_out` keeps its value across the edge.
- R6: The internal two-bit mode select is 2'b00 for hold, 2'b01 for load, 2'b10 for shift right and 2'b11 for shift left. It is chosen in the priority order load, then shift right, then shift left.
- R7: `q_out` changes only at a rising clock edge. Changing the inputs between edges leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low, clears the register |
| req_load | input | 1 | Request a parallel load (highest priority) |
| req_shr | input | 1 | Request a shift toward bit 0 |
| req_shl | input | 1 | Request a shift toward the top bit (lowest priority) |
| par_in | input | WIDTH | Parallel data word |
| ser_msb_in | input | 1 | Serial bit that enters the top bit on a right shift |
| ser_lsb_in | input | 1 | Serial bit that enters bit 0 on a left shift |
| q_out | output | WIDTH | Current register contents |

## Verification
The bench builds the register with WIDTH set to 8. This is wide enough that both end bits and several interior bits are distinct, so a shift that drops or duplicates a bit, or that feeds the wrong serial input, shows up as a wrong value. All eight combinations of the request lines are driven with varied data and serial bits, so every priority conflict is exercised. Reset is asserted while load is requested, to check that reset overrides it. Inputs are also changed between edges to check that the output only moves at a clock edge.

// File: rtl/psr_pkg.sv
// Package: shared mode encoding for the prioritized shift/load register.
// Assumes nothing beyond a two-bit select feeding a four-way mux.
package psr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_LOAD = 2'b01,
        MODE_SHR  = 2'b10,
        MODE_SHL  = 2'b11
    } psr_mode_e;
endpackage

// File: rtl/psr_prio_enc.sv
// Module: fixed-priority encoder turning three request lines into a mode.
// Assumes requests are level signals sampled by the register's clock;
// priority is load, then shift right, then shift left, else hold.
module psr_prio_enc
    import psr_pkg::*;
(
    input  logic      load_i,
    input  logic      shr_i,
    input  logic      shl_i,
    output psr_mode_e mode_o
);
    // Resolve simultaneous requests by fixed priority.
    always_comb begin
        if (load_i)     mode_o = MODE_LOAD;
        else if (shr_i) mode_o = MODE_SHR;
        else if (shl_i) mode_o = MODE_SHL;
        else            mode_o = MODE_HOLD;
    end
endmodule

// File: rtl/psr_bit_mux.sv
// Module: four-way next-state selector for one register bit.
// Assumes the caller supplies the neighbour bits (or serial inputs at ends).
module psr_bit_mux
    import psr_pkg::*;
(
    input  psr_mode_e mode_i,
    input  logic      cur_i,
    input  logic      par_i,
    input  logic      upper_i,
    input  logic      lower_i,
    output logic      next_o
);
    // Pick the bit's next value from hold, load, or a neighbour.
    always_comb begin
        unique case (mode_i)
            MODE_HOLD: next_o = cur_i;
            MODE_LOAD: next_o = par_i;
            MODE_SHR:  next_o = upper_i;
            MODE_SHL:  next_o = lower_i;
            default:   next_o = cur_i;
        endcase
    end
endmodule

// File: rtl/prio_shift_reg.sv
// Module: WIDTH-bit register with prioritized load / shift-right / shift-left.
// Assumes a single clock; reset is synchronous and active low, and it
// overrides all requests. Shift right moves bits toward bit 0.
module prio_shift_reg
    import psr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_load,
    input  logic             req_shr,
    input  logic             req_shl,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_msb_in,
    input  logic             ser_lsb_in,
    output logic [WIDTH-1:0] q_out
);
    localparam int TOP = WIDTH - 1;

    psr_mode_e        mode_sel;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    psr_prio_enc u_enc (
        .load_i (req_load),
        .shr_i  (req_shr),
        .shl_i  (req_shl),
        .mode_o (mode_sel)
    );

    // One selector per bit; the end bits take the serial inputs.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic up_b;
        logic lo_b;
        if (i == TOP) begin : g_top
            assign up_b = ser_msb_in;
        end else begin : g_mid_up
            assign up_b = state_q[i+1];
        end
        if (i == 0) begin : g_bot
            assign lo_b = ser_lsb_in;
        end else begin : g_mid_lo
            assign lo_b = state_q[i-1];
        end
        psr_bit_mux u_mux (
            .mode_i  (mode_sel),
            .cur_i   (state_q[i]),
            .par_i   (par_in[i]),
            .upper_i (up_b),
            .lower_i (lo_b),
            .next_o  (state_d[i])
        );
    end

    // Register the selected next state; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign q_out = state_q;
endmodule

// File: rtl/prio_shift_reg_chk.sv
// Module: assertion checker for prio_shift_reg, attached by bind.
// Assumes it observes the top ports and the internal mode select.
module prio_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_load,
    input logic             req_shr,
    input logic             req_shl,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_msb_in,
    input logic             ser_lsb_in,
    input logic [WIDTH-1:0] q_out,
    input logic [1:0]       mode
);
    // R1: reset clears the register
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> q_out == '0);

    // R2: load wins
    a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req_load |=> q_out == $past(par_in));

    // R3: right shift, top bit from serial input
    a_r3_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_load && req_shr) |=>
        q_out == {$past(ser_msb_in), $past(q_out[WIDTH-1:1])});

    // R4: left shift, bit 0 from serial input
    a_r4_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_load && !req_shr && req_shl) |=>
        q_out == {$past(q_out[WIDTH-2:0]), $past(ser_lsb_in)});

    // R5: no request holds the value
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_load && !req_shr && !req_shl) |=> $stable(q_out));

    // R6: encoder output matches priority and encoding
    a_r6_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        req_load |-> mode == 2'b01);
    a_r6_mode_shr: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_load && req_shr) |-> mode == 2'b10);
    a_r6_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_load && !req_shr && !req_shl) |-> mode == 2'b00);
endmodule

bind prio_shift_reg prio_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_load   (req_load),
    .req_shr    (req_shr),
    .req_shl    (req_shl),
    .par_in     (par_in),
    .ser_msb_in (ser_msb_in),
    .ser_lsb_in (ser_lsb_in),
    .q_out      (q_out),
    .mode       (mode_sel)
);

// File: tb/tb_prio_shift_reg.sv
`timescale 1ns/1ps
module tb_prio_shift_reg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_load = 1'b0, req_shr = 1'b0, req_shl = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_msb_in = 1'b0, ser_lsb_in = 1'b0;
    logic [W-1:0] q_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] model = '0;

    prio_shift_reg #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_shr(req_shr),
        .req_shl(req_shl), .par_in(par_in), .ser_msb_in(ser_msb_in),
        .ser_lsb_in(ser_lsb_in), .q_out(q_out)
    );

    always #2.5 clk = ~clk;

    // Stimulus vectors: {load, shr, shl, msb_in, lsb_in, par[7:0]}
    localparam int NV = 16;
    localparam logic [12:0] VEC [NV] = '{
        {5'b10000, 8'hA5}, {5'b01010, 8'h00}, {5'b01110, 8'hFF},
        {5'b00101, 8'h3C}, {5'b00101, 8'h00}, {5'b00000, 8'hFF},
        {5'b11100, 8'h5A}, {5'b10111, 8'h81}, {5'b01001, 8'h00},
        {5'b00111, 8'h77}, {5'b01011, 8'h12}, {5'b00000, 8'h00},
        {5'b11011, 8'hC3}, {5'b00100, 8'hEE}, {5'b00110, 8'h00},
        {5'b01111, 8'h99}
    };

    task automatic check(input string req, input logic [W-1:0] exp);
        n_cmp++;
        if (q_out !== exp) begin
            n_bad++;
            $display("FAIL %s: q_out=%h expected=%h", req, q_out, exp);
        end
    endtask

    function automatic string req_of(input logic l, input logic r, input logic s);
        if (l) return "R2";
        if (r) return "R3";
        if (s) return "R4";
        return "R5";
    endfunction

    // Drive one cycle at the falling edge, update the model, check after the rising edge.
    task automatic step(input logic l, input logic r, input logic s,
                        input logic mi, input logic li, input logic [W-1:0] d);
        @(negedge clk);
        req_load = l; req_shr = r; req_shl = s;
        ser_msb_in = mi; ser_lsb_in = li; par_in = d;
        if (l)      model = d;
        else if (r) model = {mi, model[W-1:1]};
        else if (s) model = {model[W-2:0], li};
        @(posedge clk); #1;
        check(req_of(l, r, s), model);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        req_load = 1'b1; par_in = 8'hFF;
        repeat (2) @(posedge clk); #1;
        check("R1", '0);
        @(negedge clk); rst_n = 1'b1; req_load = 1'b0;

        // Table walk, covering all request combinations
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
        end

        // Random data over all 8 combinations
        for (int i = 0; i < 64; i++) begin
            logic [2:0] c;
            c = 3'(i % 8);
            step(c[2], c[1], c[0], 1'($urandom), 1'($urandom), W'($urandom));
        end

        // R3/R4: a full walk of one bit through each direction
        step(1, 0, 0, 0, 0, 8'h01);
        for (int i = 0; i < W; i++) step(0, 0, 1, 0, 0, 8'h00);
        step(1, 0, 0, 0, 0, 8'h80);
        for (int i = 0; i < W; i++) step(0, 1, 1, 0, 1, 8'h00);

        // R7: inputs toggled between edges leave q_out unchanged
        step(1, 0, 0, 0, 0, 8'h6B);
        @(negedge clk);
        req_load = 1'b1; par_in = 8'h00; #1;
        check("R7", model);
        req_load = 1'b0; req_shr = 1'b1; ser_msb_in = 1'b1; #1;
        check("R7", model);
        req_shr = 1'b0; req_shl = 1'b0;
        @(posedge clk); #1;
        check("R5", model);

        // R1: reset overrides a pending load
        @(negedge clk);
        rst_n = 1'b0; req_load = 1'b1; par_in = 8'hF0;
        @(posedge clk); #1;
        check("R1", '0);
        @(negedge clk); rst_n = 1'b1; req_load = 1'b0; model = '0;
        step(0, 0, 0, 1, 1, 8'hAA);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule